// File: doc/BRIEF.md
# Tile Load Controller

This block serves one tile request at a time for a single matrix operand. A sequencer raises a request with a tag for exactly one cycle; the controller keeps that tag, asks the tile cache whether the line is present, and then fills a downstream buffer with the tile's words. On a hit, the words come out of the cache data memory. On a miss, they come from a DMA engine.

On a hit the cache memory has a one-cycle read latency. The controller therefore issues reads one cycle ahead of the buffer writes and lags the write address by one. On a miss it requests the tile from the DMA engine and waits for acknowledge. It then passes every arriving word to the cache fill port and to the buffer write port in the same cycle, so the cache refill adds no cycles to a plain DMA load. A final one-cycle step pulses load-done to the sequencer and, after a miss only, commits the new line in the cache.

The states are IDLE, LOOKUP, HIT_STREAM, MISS_REQ, MISS_FILL and DONE. Their transitions are:
- IDLE to LOOKUP on a request.
- LOOKUP to HIT_STREAM on a hit, or to MISS_REQ on a miss.
- HIT_STREAM to DONE after TILE_WORDS+1 cycles.
- MISS_REQ to MISS_FILL on acknowledge.
- MISS_FILL to DONE after the last word.
- DONE to IDLE unconditionally.

Top module: `tile_load_ctrl`

## Requirements
- R1: After reset, the controller is idle. `lu_valid`, `rd_en`, `dst_we`, `fill_we`, `fill_done`, `dma_req` and `load_done` are all low.
- R2: In the cycle after `req_valid` is seen in IDLE, `lu_valid` is high for exactly one cycle and `line_tag` equals the tag present on the request cycle. This holds even if `req_tag` changes afterwards.
- R3: On a hit, the stream lasts TILE_WORDS+1 cycles, counted from the cycle after the lookup. In stream cycle i, `rd_en` is high for i < TILE_WORDS with `rd_addr` = i. `dst_we` is high for i >= 1 with `dst_addr` = i-1 and `dst_data` equal to the cache read data returned for that address.
- R4: A hit never raises `fill_we`, `fill_done` or `dma_req`.
- R5: On a miss, `dma_req` rises in the cycle after the lookup with `dma_tile_id` equal to the captured tag. Both are held until a cycle in which `dma_ack` is high, and `dma_req` is low from the next cycle on.
- R6: In MISS_FILL, a cycle with `dma_we` high drives `fill_we` and `dst_we` high in that same cycle, with `fill_addr` = `dst_addr` = `dma_addr` and `fill_data` = `dst_data` = `dma_data`. A cycle with `dma_we` low writes neither port.
- R7: `load_done` is a one-cycle pulse. `fill_done` pulses with it only after a miss, with `line_tag` still equal to the captured tag.
- R8: `load_done` is high TILE_WORDS+3 cycles after the request cycle on a hit. On a miss, it is high one cycle after the cycle that carries the last DMA word; with back-to-back words, that is TILE_WORDS+1 cycles after the acknowledge cycle.
- R9: A request raised while the controller is not in IDLE is ignored. It starts no lookup and does not change the tag or data being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle tile request |
| req_tag | input | TAG_W | Tag of the requested tile, valid with req_valid |
| load_done | output | 1 | One-cycle pulse when the buffer holds the tile |
| lu_valid | output | 1 | Cache lookup strobe |
| lu_hit | input | 1 | Combinational hit result for the lookup |
| line_tag | output | TAG_W | Captured tag, used by the cache for lookup, read, fill and commit |
| rd_en | output | 1 | Cache data read enable |
| rd_addr | output | ADDR_W | Word index to read |
| rd_data | input | WORD_W | Cache read data, one cycle after rd_en |
| fill_we | output | 1 | Cache fill write strobe |
| fill_addr | output | ADDR_W | Cache fill word index |
| fill_data | output | WORD_W | Cache fill word |
| fill_done | output | 1 | Commit tag and valid of the filled line |
| dma_req | output | 1 | DMA tile request |
| dma_tile_id | output | TAG_W | Tile to fetch |
| dma_ack | input | 1 | DMA ready to send words |
| dma_we | input | 1 | DMA word strobe |
| dma_addr | input | ADDR_W | DMA word index |
| dma_data | input | WORD_W | DMA word |
| dst_we | output | 1 | Downstream buffer write strobe |
| dst_addr | output | ADDR_W | Downstream buffer word index |
| dst_data | output | WORD_W | Downstream buffer word |

## Verification
The bench builds the block with TILE_WORDS = 5, WORD_W = 16 and TAG_W = 8. Five words is not a power of two, which makes the stream counter run to 5 in a 3-bit field and exercises the lagged write address at a width that does not wrap cleanly. The bench acknowledges misses after delays of zero and several cycles, and sends DMA words in descending address order with a one-cycle bubble. This shows that the fill address follows the DMA engine and that a stalled word writes nothing. It also pokes a new request mid-stream, changes the request tag during the lookup, and issues requests back to back.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_LOOKUP     = 3'd1,
        S_HIT_STREAM = 3'd2,
        S_MISS_REQ   = 3'd3,
        S_MISS_FILL  = 3'd4,
        S_DONE       = 3'd5
    } tlc_state_e;

endpackage

// File: rtl/tlc_tag_latch.sv
module tlc_tag_latch #(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAG_W-1:0] d,
    output logic [TAG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/tlc_word_cnt.sv
module tlc_word_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tile_load_ctrl.sv
module tile_load_ctrl #(
    parameter int TILE_WORDS = 3,
    parameter int WORD_W     = 24,
    parameter int TAG_W      = 8,
    localparam int ADDR_W    = (TILE_WORDS > 1) ? $clog2(TILE_WORDS) : 1,
    localparam int CNT_W     = $clog2(TILE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              load_done,
    output logic              lu_valid,
    input  logic              lu_hit,
    output logic [TAG_W-1:0]  line_tag,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              fill_we,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [WORD_W-1:0] fill_data,
    output logic              fill_done,
    output logic              dma_req,
    output logic [TAG_W-1:0]  dma_tile_id,
    input  logic              dma_ack,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [WORD_W-1:0] dma_data,
    output logic              dst_we,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [WORD_W-1:0] dst_data
);
    import tlc_pkg::*;

    localparam logic [CNT_W-1:0] LAST_HIT  = CNT_W'(TILE_WORDS);
    localparam logic [CNT_W-1:0] LAST_MISS = CNT_W'(TILE_WORDS - 1);

    tlc_state_e       state_q, state_d;
    logic [CNT_W-1:0] word_cnt;
    logic [CNT_W-1:0] word_cnt_m1;
    logic             cnt_clr, cnt_inc;
    logic             tag_load;
    logic             was_miss_q;

    // Tag is only valid on the request cycle: capture it there.
    assign tag_load = (state_q == S_IDLE) && req_valid;

    tlc_tag_latch #(.TAG_W(TAG_W)) u_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tag_load),
        .d     (req_tag),
        .q     (line_tag)
    );

    assign cnt_clr = (state_q == S_LOOKUP) || (state_q == S_MISS_REQ);
    assign cnt_inc = (state_q == S_HIT_STREAM) ||
                     ((state_q == S_MISS_FILL) && dma_we);

    tlc_word_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (word_cnt)
    );

    assign word_cnt_m1 = word_cnt - CNT_W'(1);

    // Remembers which path led to DONE, so only a miss commits the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_miss_q <= 1'b0;
        end else if (state_q == S_LOOKUP) begin
            was_miss_q <= !lu_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (req_valid) state_d = S_LOOKUP;
            S_LOOKUP:     state_d = lu_hit ? S_HIT_STREAM : S_MISS_REQ;
            S_HIT_STREAM: if (word_cnt == LAST_HIT) state_d = S_DONE;
            S_MISS_REQ:   if (dma_ack) state_d = S_MISS_FILL;
            S_MISS_FILL:  if (dma_we && word_cnt == LAST_MISS) state_d = S_DONE;
            S_DONE:       state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    always_comb begin
        lu_valid    = 1'b0;
        rd_en       = 1'b0;
        rd_addr     = '0;
        fill_we     = 1'b0;
        fill_addr   = '0;
        fill_data   = '0;
        fill_done   = 1'b0;
        dma_req     = 1'b0;
        dma_tile_id = line_tag;
        dst_we      = 1'b0;
        dst_addr    = '0;
        dst_data    = '0;
        load_done   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_LOOKUP: lu_valid = 1'b1;
            S_HIT_STREAM: begin
                rd_en   = (word_cnt < LAST_HIT);
                rd_addr = ADDR_W'(word_cnt);
                if (word_cnt != '0) begin
                    dst_we   = 1'b1;
                    dst_addr = ADDR_W'(word_cnt_m1);
                    dst_data = rd_data;
                end
            end
            S_MISS_REQ: dma_req = 1'b1;
            S_MISS_FILL: begin
                if (dma_we) begin
                    fill_we   = 1'b1;
                    fill_addr = dma_addr;
                    fill_data = dma_data;
                    dst_we    = 1'b1;
                    dst_addr  = dma_addr;
                    dst_data  = dma_data;
                end
            end
            S_DONE: begin
                load_done = 1'b1;
                fill_done = was_miss_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
    parameter int TAG_W  = 8,
    parameter int WORD_W = 24,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [TAG_W-1:0]  req_tag,
    input logic              lu_valid,
    input logic [TAG_W-1:0]  line_tag,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              dst_we,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [WORD_W-1:0] dst_data,
    input logic              fill_we,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [WORD_W-1:0] fill_data,
    input logic              fill_done,
    input logic              load_done,
    input logic              dma_req,
    input logic              dma_ack,
    input logic [TAG_W-1:0]  dma_tile_id
);

    AST_LOOKUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lu_valid |=> !lu_valid);                                                // R2
    AST_LOOKUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        lu_valid |-> ($past(req_valid) && line_tag == $past(req_tag)));          // R2
    AST_WRITE_LAGS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (dst_we && dst_addr == $past(rd_addr)));                      // R3
    AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (!fill_we && !dma_req && !fill_done));                        // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> (dma_req && $stable(dma_tile_id)));           // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);                                     // R5
    AST_FILL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (dst_we && dst_addr == fill_addr && dst_data == fill_data)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);                                              // R7
    AST_COMMIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> load_done);                                               // R7

endmodule

bind tile_load_ctrl tlc_checker #(
    .TAG_W  (TAG_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_tlc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_tag     (req_tag),
    .lu_valid    (lu_valid),
    .line_tag    (line_tag),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .dst_we      (dst_we),
    .dst_addr    (dst_addr),
    .dst_data    (dst_data),
    .fill_we     (fill_we),
    .fill_addr   (fill_addr),
    .fill_data   (fill_data),
    .fill_done   (fill_done),
    .load_done   (load_done),
    .dma_req     (dma_req),
    .dma_ack     (dma_ack),
    .dma_tile_id (dma_tile_id)
);

// File: tb/tile_load_ctrl_test.sv
module tile_load_ctrl_test;

    localparam int K  = 5;
    localparam int WW = 16;
    localparam int TW = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic          load_done, lu_valid, rd_en, fill_we, fill_done, dma_req, dst_we;
    logic          lu_hit = 1'b0;
    logic [TW-1:0] line_tag, dma_tile_id;
    logic [AW-1:0] rd_addr, fill_addr, dst_addr;
    logic [WW-1:0] rd_data = '0;
    logic [WW-1:0] fill_data, dst_data;
    logic          dma_ack = 1'b0;
    logic          dma_we = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [WW-1:0] dma_data = '0;

    int checks = 0;
    int errors = 0;
    int wd     = 0;

    always #10 clk = ~clk;

    tile_load_ctrl #(.TILE_WORDS(K), .WORD_W(WW), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .load_done(load_done), .lu_valid(lu_valid), .lu_hit(lu_hit),
        .line_tag(line_tag), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_done(fill_done), .dma_req(dma_req), .dma_tile_id(dma_tile_id),
        .dma_ack(dma_ack), .dma_we(dma_we), .dma_addr(dma_addr), .dma_data(dma_data),
        .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data)
    );

    function automatic logic [WW-1:0] cpat(input logic [TW-1:0] t, input int a);
        return {t, 8'(a)} ^ 16'hA5C3;
    endfunction

    function automatic logic [WW-1:0] dpat(input logic [TW-1:0] t, input int a);
        return {8'(a * 7 + 1), t} ^ 16'h3C0F;
    endfunction

    // Cache data memory model: one-cycle read latency.
    always @(posedge clk) rd_data <= cpat(line_tag, int'(rd_addr));

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", wd, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!lu_valid && !rd_en && !dst_we && !fill_we, "R1 strobes", {lu_valid, rd_en, dst_we, fill_we}, 0);
        chk(!fill_done && !dma_req && !load_done, "R1 done/req", {fill_done, dma_req, load_done}, 0);
    endtask

    task automatic t_hit(input logic [TW-1:0] t, input bit poke);
        @(negedge clk);
        req_valid = 1'b1; req_tag = t;
        #1;
        @(negedge clk);
        req_valid = 1'b0; req_tag = ~t; lu_hit = 1'b1;
        #1;
        chk(lu_valid, "R2 lookup strobe", lu_valid, 1);
        chk(line_tag == t, "R2 captured tag", line_tag, t);
        for (int i = 0; i <= K; i++) begin
            @(negedge clk);
            lu_hit = 1'b0;
            if (poke && i == 1) begin req_valid = 1'b1; req_tag = t ^ 8'h55; end
            else req_valid = 1'b0;
            #1;
            chk(rd_en == (i < K), "R3 rd_en", rd_en, (i < K));
            if (i < K) chk(rd_addr == AW'(i), "R3 rd_addr", rd_addr, i);
            chk(dst_we == (i > 0), "R3 dst_we", dst_we, (i > 0));
            if (i > 0) begin
                chk(dst_addr == AW'(i - 1), "R3 dst_addr", dst_addr, i - 1);
                chk(dst_data == cpat(t, i - 1), "R3/R9 dst_data", dst_data, cpat(t, i - 1));
            end
            chk(!fill_we && !dma_req, "R4 no fill on hit", {fill_we, dma_req}, 0);
            chk(!lu_valid, "R9 no lookup while busy", lu_valid, 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(load_done, "R8 hit done at K+3", load_done, 1);
        chk(!fill_done, "R4 no commit on hit", fill_done, 0);
        @(negedge clk);
        #1;
        chk(!load_done, "R7 done pulse", load_done, 0);
        chk(!lu_valid, "R9 busy request dropped", lu_valid, 0);
    endtask

    task automatic t_miss(input logic [TW-1:0] t, input int wait_n, input bit gap);
        int span;
        @(negedge clk);
        req_valid = 1'b1; req_tag = t;
        #1;
        @(negedge clk);
        req_valid = 1'b0; req_tag = 8'h00; lu_hit = 1'b0;
        #1;
        chk(lu_valid && line_tag == t, "R2 lookup tag", line_tag, t);
        for (int w = 0; w < wait_n; w++) begin
            @(negedge clk);
            dma_ack = 1'b0;
            #1;
            chk(dma_req, "R5 req held", dma_req, 1);
            chk(dma_tile_id == t, "R5 tile id", dma_tile_id, t);
        end
        @(negedge clk);
        dma_ack = 1'b1;
        #1;
        chk(dma_req && dma_tile_id == t, "R5 req at ack", dma_tile_id, t);
        span = 0;
        for (int j = 0; j < K; j++) begin
            if (gap && j == 2) begin
                @(negedge clk);
                dma_ack = 1'b0; dma_we = 1'b0;
                span++;
                #1;
                chk(!fill_we && !dst_we, "R6 bubble writes nothing", {fill_we, dst_we}, 0);
            end
            @(negedge clk);
            dma_ack = 1'b0; dma_we = 1'b1;
            dma_addr = AW'(K - 1 - j); dma_data = dpat(t, j);
            span++;
            #1;
            chk(!dma_req, "R5 req dropped", dma_req, 0);
            chk(fill_we && dst_we, "R6 both strobes", {fill_we, dst_we}, 3);
            chk(fill_addr == AW'(K - 1 - j), "R6 fill_addr", fill_addr, K - 1 - j);
            chk(dst_addr == AW'(K - 1 - j), "R6 dst_addr", dst_addr, K - 1 - j);
            chk(fill_data == dpat(t, j), "R6 fill_data", fill_data, dpat(t, j));
            chk(dst_data == dpat(t, j), "R6 dst_data", dst_data, dpat(t, j));
            chk(!load_done, "R8 not early", load_done, 0);
        end
        @(negedge clk);
        dma_we = 1'b0;
        span++;
        #1;
        chk(load_done, "R8 miss done", load_done, 1);
        chk(span == K + 1 + (gap ? 1 : 0), "R8 miss span", span, K + 1 + (gap ? 1 : 0));
        chk(fill_done, "R7 commit on miss", fill_done, 1);
        chk(line_tag == t, "R7 commit tag", line_tag, t);
        @(negedge clk);
        #1;
        chk(!load_done && !fill_done, "R7 pulses end", {load_done, fill_done}, 0);
    endtask

    initial begin
        t_reset();
        t_hit(8'h03, 1'b0);
        t_miss(8'h81, 0, 1'b0);
        t_miss(8'h42, 3, 1'b1);
        t_hit(8'h42, 1'b1);
        t_hit(8'h07, 1'b0);
        t_reset();
        t_miss(8'hFE, 1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule